// File: doc/BRIEF.md
# Hot-plug slot power sequencer

This block brings one hot-plug expansion slot from unpowered to running. It takes the slot's capability bits, a slot-control word written by software, a raw active-low latch (MRL) sensor line and an attention-button line. It drives four active-low slot outputs: power enable, power indicator LED, reference clock enable and slot reset. The latch sensor is synchronised and debounced, and each accepted latch change or button press sets a sticky status flag. The hot-plug interrupt is raised when the matching enable bits allow it.

Power-up starts from the off state when software holds the power-controller control bit at 0 and a start event is present. With a latch sensor fitted, the start event is a closed latch. Without one, it is an earlier button press. The sequence then runs through fixed phases. Power enable is asserted first. The clock, and the LED if one is fitted, follow once power is valid. Slot reset is released last. All delays are counted in ticks from a shared prescaler. With the default divider one tick is 1 ms at a 100 MHz clock.

Top module: `slot_pwr_seq`

## Requirements
- R1: A level change on `mrl_ni`, in either direction, is accepted only once the new level has been held for DEB_MS ticks. A pulse shorter than DEB_MS-1 ticks is ignored.
- R2: A closed latch (`mrl_ni` debounced low) starts power-up only when `slot_cap_i[1]` (power controller fitted) and `slot_cap_i[2]` (latch sensor fitted) are both 1. With `slot_cap_i[1]`=0 nothing starts.
- R3: While `slot_ctl_i[10]` is 1 the slot stays unpowered (`pwr_en_no`=1). A start needs `slot_ctl_i[10]`=0.
- R4: Each accepted latch change sets status flag `sts_o[0]` when `slot_cap_i[2]`=1. That flag drives `irq_o` only when `slot_ctl_i[5]` and `slot_ctl_i[2]` are both 1.
- R5: A rising edge on `attn_i` sets status flag `sts_o[1]`, which drives `irq_o` when `slot_ctl_i[5]` and `slot_ctl_i[0]` are both 1. With `slot_cap_i[2]`=0 the press arms a power-up that starts once `slot_ctl_i[10]` is 0.
- R6: `pwr_en_no` falls first. `clk_en_no` falls PV_MS ticks later, within one tick of prescaler phase, and `pwr_led_no` falls in the same cycle.
- R7: `slot_rst_no` stays low until RST_MS ticks after `clk_en_no` falls, within one tick of prescaler phase, and then rises.
- R8: `pwr_led_no` is never driven low while `slot_cap_i[4]` is 0.
- R9: Setting `slot_ctl_i[10]` to 1 during any powered phase returns the block to off at the next clock edge: `slot_rst_no` low, and `clk_en_no`, `pwr_led_no` and `pwr_en_no` high.
- R10: A status flag stays set until a 1 is written on its bit of `sts_clr_i` for one cycle. `irq_o` is the OR of the flags whose enables are set.
- R11: After reset `pwr_en_no`, `pwr_led_no` and `clk_en_no` are 1, and `slot_rst_no`, `irq_o` and `sts_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_cap_i | input | 5 | Capabilities: [1] power controller, [2] latch sensor, [4] power LED |
| slot_ctl_i | input | 16 | Control: [10] power off, [5] hot-plug irq enable, [2] latch irq enable, [0] button irq enable |
| mrl_ni | input | 1 | Raw latch sensor, low = closed |
| attn_i | input | 1 | Attention button, high = pressed |
| sts_clr_i | input | 2 | Write-1-to-clear strobes for the status flags |
| pwr_en_no | output | 1 | Slot power enable, active low |
| pwr_led_no | output | 1 | Power indicator, active low |
| clk_en_no | output | 1 | Reference clock enable, active low |
| slot_rst_no | output | 1 | Slot reset, active low |
| irq_o | output | 1 | Hot-plug interrupt |
| sts_o | output | 2 | Status flags: [0] latch changed, [1] button pressed |

## Verification
The bench builds the block with TICK_DIV=4 and keeps the delays at DEB_MS=10, PV_MS=16 and RST_MS=100. A millisecond tick therefore lasts four cycles. The full debounce window and power-up sequence fit in a few hundred cycles, and the phase edges can be measured against exact cycle windows that allow one tick of prescaler phase. A glitch of five ticks exercises the reject path of the debouncer without long waits.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;
  typedef enum logic [1:0] {
    S_OFF      = 2'd0,
    S_PV_WAIT  = 2'd1,
    S_RST_WAIT = 2'd2,
    S_ON       = 2'd3
  } seq_state_e;

  localparam int unsigned CTL_PWR_OFF  = 10;
  localparam int unsigned CTL_HP_IE    = 5;
  localparam int unsigned CTL_MRL_IE   = 2;
  localparam int unsigned CTL_ATTN_IE  = 0;
  localparam int unsigned CAP_PWR_CTRL = 1;
  localparam int unsigned CAP_MRL      = 2;
  localparam int unsigned CAP_PWR_IND  = 4;
  localparam int unsigned STS_MRL      = 0;
  localparam int unsigned STS_ATTN     = 1;
  localparam int unsigned N_STS        = 2;
endpackage

// File: rtl/slot_tick_gen.sv
module slot_tick_gen #(
  parameter int unsigned DIV = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/slot_debounce.sv
module slot_debounce #(
  parameter int unsigned DEB_TICKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  output logic level_o,
  output logic chg_o
);
  localparam int unsigned CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      cnt_q   <= '0;
      level_o <= 1'b1;
      chg_o   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      chg_o  <= 1'b0;
      if (sync_q[1] == level_o) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == LAST) begin
          level_o <= sync_q[1];
          cnt_q   <= '0;
          chg_o   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // accepted level must match the synchronised input seen before
  assert_settle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != $past(level_o)) |-> (level_o == $past(sync_q[1])));

  assert_chg_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |=> !chg_o);
endmodule

// File: rtl/slot_irq.sv
module slot_irq #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  input  logic         hp_ie_i,
  output logic [N-1:0] sts_o,
  output logic         irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_o[i] <= 1'b0;
      else         sts_o[i] <= set_i[i] | (sts_o[i] & ~clr_i[i]); // set wins
    end

    assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_o[i] && !clr_i[i]) |=> sts_o[i]);
  end

  assign irq_o = hp_ie_i & |(sts_o & en_i);

  assert_irq_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hp_ie_i |-> !irq_o);
endmodule

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq
  import slot_pwr_pkg::*;
#(
  parameter int unsigned TICK_DIV = 100000,
  parameter int unsigned DEB_MS   = 10,
  parameter int unsigned PV_MS    = 16,
  parameter int unsigned RST_MS   = 100
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [4:0]  slot_cap_i,
  input  logic [15:0] slot_ctl_i,
  input  logic        mrl_ni,
  input  logic        attn_i,
  input  logic [1:0]  sts_clr_i,
  output logic        pwr_en_no,
  output logic        pwr_led_no,
  output logic        clk_en_no,
  output logic        slot_rst_no,
  output logic        irq_o,
  output logic [1:0]  sts_o
);
  localparam int unsigned TMAX = (PV_MS > RST_MS) ? PV_MS : RST_MS;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] PV_LAST  = TW'(PV_MS - 1);
  localparam logic [TW-1:0] RST_LAST = TW'(RST_MS - 1);

  logic tick, mrl_level, mrl_chg;
  logic [2:0] attn_q;
  logic attn_rise, armed_q;
  seq_state_e state_q;
  logic [TW-1:0] tmr_q;

  logic pwr_off, has_pc, has_mrl, start_evt, clk_phase;
  logic unused_bits;

  assign pwr_off  = slot_ctl_i[CTL_PWR_OFF];
  assign has_pc   = slot_cap_i[CAP_PWR_CTRL];
  assign has_mrl  = slot_cap_i[CAP_MRL];
  assign unused_bits = ^{slot_ctl_i[15:11], slot_ctl_i[9:6], slot_ctl_i[4:3],
                         slot_ctl_i[1], slot_cap_i[3], slot_cap_i[0]};

  slot_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  slot_debounce #(.DEB_TICKS(DEB_MS)) u_deb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .raw_i  (mrl_ni),
    .level_o(mrl_level),
    .chg_o  (mrl_chg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) attn_q <= '0;
    else         attn_q <= {attn_q[1:0], attn_i};
  end
  assign attn_rise = attn_q[1] & ~attn_q[2];

  slot_irq #(.N(N_STS)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({attn_rise, mrl_chg & has_mrl}),
    .clr_i  (sts_clr_i),
    .en_i   ({slot_ctl_i[CTL_ATTN_IE], slot_ctl_i[CTL_MRL_IE]}),
    .hp_ie_i(slot_ctl_i[CTL_HP_IE]),
    .sts_o  (sts_o),
    .irq_o  (irq_o)
  );

  // latch closed with sensor fitted, or a pending button press without one
  assign start_evt = has_mrl ? (has_pc & ~mrl_level) : armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_OFF;
      tmr_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (attn_rise && !has_mrl) armed_q <= 1'b1;
      if (pwr_off && state_q != S_OFF) begin
        state_q <= S_OFF;
        tmr_q   <= '0;
      end else begin
        case (state_q)
          S_OFF: begin
            tmr_q <= '0;
            if (!pwr_off && has_pc && start_evt) begin
              state_q <= S_PV_WAIT;
              armed_q <= 1'b0;
            end
          end
          S_PV_WAIT: if (tick) begin
            if (tmr_q == PV_LAST) begin
              state_q <= S_RST_WAIT;
              tmr_q   <= '0;
            end else tmr_q <= tmr_q + 1'b1;
          end
          S_RST_WAIT: if (tick) begin
            if (tmr_q == RST_LAST) begin
              state_q <= S_ON;
              tmr_q   <= '0;
            end else tmr_q <= tmr_q + 1'b1;
          end
          default: tmr_q <= '0;
        endcase
      end
    end
  end

  assign clk_phase = (state_q == S_RST_WAIT) || (state_q == S_ON);

  always_comb begin
    pwr_en_no   = (state_q == S_OFF);
    clk_en_no   = ~clk_phase;
    pwr_led_no  = ~(clk_phase & slot_cap_i[CAP_PWR_IND]);
    slot_rst_no = (state_q == S_ON);
  end

  assert_no_pc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_no && !has_pc) |=> pwr_en_no);

  assert_hold_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_no && pwr_off) |=> pwr_en_no);

  assert_clk_after_pwr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_no |-> !pwr_en_no);

  assert_rst_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_rst_no |-> (!clk_en_no && !pwr_en_no));

  assert_led_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_cap_i[CAP_PWR_IND] |-> pwr_led_no);

  assert_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_off && !pwr_en_no) |=> (pwr_en_no && clk_en_no && pwr_led_no && !slot_rst_no));
endmodule

// File: tb/slot_pwr_seq_bench.sv
module slot_pwr_seq_bench;
  localparam int DIV = 4;
  localparam int DEB = 10;
  localparam int PV  = 16;
  localparam int RST = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cap = 5'b10110;
  logic [15:0] ctl = 16'h0424;
  logic        mrl_n = 1'b1;
  logic        attn = 1'b0;
  logic [1:0]  clr = 2'b00;
  logic pwr_en_n, led_n, clk_en_n, srst_n, irq;
  logic [1:0] sts;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  slot_pwr_seq #(.TICK_DIV(DIV), .DEB_MS(DEB), .PV_MS(PV), .RST_MS(RST)) u_slot_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .slot_cap_i(cap), .slot_ctl_i(ctl),
    .mrl_ni(mrl_n), .attn_i(attn), .sts_clr_i(clr),
    .pwr_en_no(pwr_en_n), .pwr_led_no(led_n), .clk_en_no(clk_en_n),
    .slot_rst_no(srst_n), .irq_o(irq), .sts_o(sts)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_sts(input logic [1:0] m);
    clr = m;
    @(negedge clk);
    clr = 2'b00;
  endtask

  task automatic t_reset;
    chk("R11", "pwr_en_no", pwr_en_n, 1);
    chk("R11", "pwr_led_no", led_n, 1);
    chk("R11", "clk_en_no", clk_en_n, 1);
    chk("R11", "slot_rst_no", srst_n, 0);
    chk("R11", "irq_o", irq, 0);
    chk("R11", "sts_o", sts, 0);
  endtask

  task automatic t_glitch;
    mrl_n = 1'b0;
    cyc(20);
    mrl_n = 1'b1;
    cyc(60);
    chk("R1", "glitch flag", sts, 0);
    chk("R1", "glitch power", pwr_en_n, 1);
  endtask

  task automatic t_debounce;
    int n = 0;
    mrl_n = 1'b0;
    while (!sts[0] && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk_rng("R1", "debounce cycles", n, (DEB-1)*DIV+1, DEB*DIV+4);
    chk("R4", "irq both enables", irq, 1);
    cyc(10);
    chk("R3", "held off by control", pwr_en_n, 1);
  endtask

  task automatic t_w1c;
    cyc(5);
    chk("R10", "flag sticky", sts[0], 1);
    clear_sts(2'b01);
    chk("R10", "flag cleared", sts[0], 0);
    chk("R10", "irq cleared", irq, 0);
  endtask

  task automatic t_irq_gate;
    ctl = 16'h0404;
    mrl_n = 1'b1;
    cyc(60);
    chk("R4", "flag on open", sts[0], 1);
    chk("R4", "irq without hp enable", irq, 0);
    clear_sts(2'b01);
    ctl = 16'h0420;
    mrl_n = 1'b0;
    cyc(60);
    chk("R4", "flag on close", sts[0], 1);
    chk("R4", "irq without latch enable", irq, 0);
    clear_sts(2'b01);
  endtask

  task automatic t_powerup;
    int n = 0;
    ctl = 16'h0024;
    for (int i = 0; i < 4 && pwr_en_n; i++) @(negedge clk);
    chk("R2", "power starts", pwr_en_n, 0);
    chk("R6", "clock still off", clk_en_n, 1);
    while (clk_en_n && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk_rng("R6", "power-valid cycles", n, (PV-1)*DIV+1, PV*DIV);
    chk("R6", "led with clock", led_n, 0);
    n = 0;
    while (!srst_n && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk_rng("R7", "reset release cycles", n, (RST-1)*DIV+1, RST*DIV);
    chk("R7", "power held at release", pwr_en_n, 0);
  endtask

  task automatic t_abort(input string req);
    ctl[10] = 1'b1;
    @(negedge clk);
    chk(req, "abort pwr_en_no", pwr_en_n, 1);
    chk(req, "abort clk_en_no", clk_en_n, 1);
    chk(req, "abort pwr_led_no", led_n, 1);
    chk(req, "abort slot_rst_no", srst_n, 0);
  endtask

  task automatic t_no_led;
    cap = 5'b00110;
    ctl = 16'h0024;
    for (int i = 0; i < 4 && pwr_en_n; i++) @(negedge clk);
    for (int i = 0; i < 100 && clk_en_n; i++) @(negedge clk);
    chk("R6", "clock on mid run", clk_en_n, 0);
    chk("R8", "led gated off", led_n, 1);
    cyc(30);
    t_abort("R9");
    cap = 5'b10110;
  endtask

  task automatic t_button;
    cap = 5'b10010;
    ctl = 16'h0421;
    cyc(100);
    chk("R2", "latch ignored without sensor", pwr_en_n, 1);
    attn = 1'b1;
    cyc(10);
    attn = 1'b0;
    cyc(3);
    chk("R5", "button flag", sts[1], 1);
    chk("R5", "button irq", irq, 1);
    cyc(20);
    chk("R5", "armed waits for control", pwr_en_n, 1);
    ctl = 16'h0021;
    for (int i = 0; i < 4 && pwr_en_n; i++) @(negedge clk);
    chk("R5", "button start", pwr_en_n, 0);
    t_abort("R9");
    clear_sts(2'b10);
    chk("R10", "button flag cleared", sts[1], 0);
  endtask

  task automatic t_no_pc;
    cap = 5'b10100;
    ctl = 16'h0024;
    cyc(100);
    chk("R2", "no power controller latch", pwr_en_n, 1);
    cap = 5'b00000;
    attn = 1'b1;
    cyc(10);
    attn = 1'b0;
    cyc(100);
    chk("R2", "no power controller button", pwr_en_n, 1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_glitch();
    t_debounce();
    t_w1c();
    t_irq_gate();
    t_powerup();
    t_abort("R9");
    t_no_led();
    t_button();
    t_no_pc();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule